// File: doc/BRIEF.md
# SCL Duty-Cycle Clock Generator

This block derives the serial clock of a two-wire bus master from the peripheral clock. Two count inputs, written by software, set how many clock cycles SCL stays low and how many it stays high. The two lengths are independent, so the duty cycle can be uneven, as fast-mode timing needs. One full SCL period lasts the sum of the two counts. A 40 MHz peripheral clock with counts adding up to 100 gives 400 kHz. The same counts adding up to 800 on a 20 MHz clock give 25 kHz.

The master's sequencer raises the enable to start the clock. SCL then begins with a full low phase. Each count is clamped to a floor of four cycles, and a zero value counts as that floor. The generator reads each count only when a phase begins, so software may rewrite the counts at any time without making a phase of mixed length. Two single-cycle strobes mark the rising and falling SCL edges. The sequencer uses them to place its SDA updates and its sampling. When the enable drops, SCL is released high.

Top module: `scl_duty_gen`

## Requirements
- R1: While reset is asserted, `scl_o` is 1 and both `scl_rise_o` and `scl_fall_o` are 0.
- R2: In the cycle after a clock edge that samples `en` low, `scl_o` is 1 and neither strobe is asserted, whatever the count inputs hold.
- R3: When `en` is sampled high while the generator is idle, SCL goes low at that same edge with `scl_fall_o` asserted. The first phase after enabling is always a low phase.
- R4: A low phase lasts max(`low_cnt_i`, 4) clock cycles and a high phase lasts max(`high_cnt_i`, 4) clock cycles. The two lengths are set independently.
- R5: Any count value below 4, including 0, gives a phase of exactly 4 cycles.
- R6: In steady operation the distance between two consecutive rising strobes equals the sum of the two effective counts (for example, 40 + 60 gives 100 cycles).
- R7: A count is read only at the edge that starts its phase. A change of `low_cnt_i` during a low phase leaves that phase's length unchanged and applies from the next low phase.
- R8: `scl_rise_o` is high for exactly the one cycle in which `scl_o` has just gone from 0 to 1. `scl_fall_o` is high for exactly the one cycle in which `scl_o` has just gone from 1 to 0. The two strobes are never high together.
- R9: Dropping `en` in the middle of a low phase releases SCL high without a rising strobe. Enabling again restarts with a low phase of the full programmed length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| en | input | 1 | Run enable; low holds SCL released high |
| low_cnt_i | input | 16 | Clock cycles for each SCL low phase (minimum 4) |
| high_cnt_i | input | 16 | Clock cycles for each SCL high phase (minimum 4) |
| scl_o | output | 1 | SCL drive level, 1 means released |
| scl_rise_o | output | 1 | One-cycle strobe with each rising SCL edge |
| scl_fall_o | output | 1 | One-cycle strobe with each falling SCL edge |

## Verification
The case that is hardest to reach is a count rewritten part way through a phase. The new value must not change the current phase. It must change the next phase of the same kind. To reach it, the stimulus waits for a falling strobe, counts three cycles into the low phase, and then writes a new low count. It then measures the current low phase, the high phase after it, and the low phase after that. Dropping the enable in the middle of a low phase is handled the same way: the stimulus times the drop from a strobe, then confirms that SCL is released without a rising strobe and that the next low phase after re-enabling has its full length.

// File: rtl/scl_pkg.sv
package scl_pkg;

  // Floor applied to each phase length, in clock cycles.
  localparam int unsigned SCL_MIN_PHASE = 4;

  // Which SCL phase the generator is about to enter.
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } scl_phase_e;

endpackage

// File: rtl/scl_len_clamp.sv
// Turns a raw count into the load value of the phase counter:
// max(raw, MIN) - 1, so the counter reaches zero on the phase's last cycle.
module scl_len_clamp #(
  parameter int unsigned W   = 16,
  parameter int unsigned MIN = 4
) (
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] load_o
);
  localparam logic [W-1:0] MinW = W'(MIN);

  logic [W-1:0] eff;

  always_comb begin
    if (raw_i < MinW) eff = MinW;
    else              eff = raw_i;
    load_o = eff - W'(1);
  end
endmodule

// File: rtl/scl_phase_cnt.sv
// Down counter that times the current SCL phase.
module scl_phase_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr_i | load_i | (cnt_q != '0);
    if (clr_i)       cnt_d = '0;
    else if (load_i) cnt_d = load_val_i;
    else             cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/scl_edge_ctrl.sv
// Owns the SCL level, the run flag and the edge strobes.
module scl_edge_ctrl
  import scl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       cnt_zero_i,
  output logic       clr_o,
  output logic       load_o,
  output scl_phase_e next_ph_o,
  output logic       scl_o,
  output logic       rise_o,
  output logic       fall_o
);
  logic run_q, run_d;
  logic scl_q, scl_d;
  logic rise_q, rise_d;
  logic fall_q, fall_d;

  always_comb begin
    run_d     = run_q;
    scl_d     = scl_q;
    rise_d    = 1'b0;
    fall_d    = 1'b0;
    clr_o     = 1'b0;
    load_o    = 1'b0;
    next_ph_o = PH_LOW;
    if (!en) begin
      run_d = 1'b0;
      scl_d = 1'b1;
      clr_o = 1'b1;
    end else if (!run_q) begin
      run_d     = 1'b1;
      scl_d     = 1'b0;
      fall_d    = 1'b1;
      load_o    = 1'b1;
      next_ph_o = PH_LOW;
    end else if (cnt_zero_i) begin
      scl_d     = ~scl_q;
      rise_d    = ~scl_q;
      fall_d    = scl_q;
      load_o    = 1'b1;
      next_ph_o = scl_q ? PH_LOW : PH_HIGH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      scl_q  <= 1'b1;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      scl_q  <= scl_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign scl_o  = scl_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
endmodule

// File: rtl/scl_duty_gen.sv
module scl_duty_gen
  import scl_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] low_cnt_i,
  input  logic [CNT_W-1:0] high_cnt_i,
  output logic             scl_o,
  output logic             scl_rise_o,
  output logic             scl_fall_o
);
  localparam int unsigned NPH = 2;

  logic [NPH-1:0][CNT_W-1:0] raw_cnt;
  logic [NPH-1:0][CNT_W-1:0] ph_load;
  logic                      clr, load, zero;
  scl_phase_e                next_ph;
  logic [CNT_W-1:0]          load_val;

  assign raw_cnt[PH_LOW]  = low_cnt_i;
  assign raw_cnt[PH_HIGH] = high_cnt_i;

  for (genvar g = 0; g < NPH; g++) begin : g_clamp
    scl_len_clamp #(.W(CNT_W), .MIN(SCL_MIN_PHASE)) u_clamp (
      .raw_i  (raw_cnt[g]),
      .load_o (ph_load[g])
    );
  end

  assign load_val = ph_load[next_ph];

  scl_edge_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .cnt_zero_i (zero),
    .clr_o      (clr),
    .load_o     (load),
    .next_ph_o  (next_ph),
    .scl_o      (scl_o),
    .rise_o     (scl_rise_o),
    .fall_o     (scl_fall_o)
  );

  scl_phase_cnt #(.W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr),
    .load_i     (load),
    .load_val_i (load_val),
    .zero_o     (zero)
  );
endmodule

// File: rtl/scl_duty_gen_chk.sv
module scl_duty_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic scl_o,
  input logic scl_rise_o,
  input logic scl_fall_o
);
  logic [15:0] low_run_q;

  // Number of consecutive cycles SCL has been seen low (saturating).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  low_run_q <= '0;
    else if (scl_o)              low_run_q <= '0;
    else if (low_run_q != 16'hFFFF) low_run_q <= low_run_q + 16'd1;
  end

  p_excl_strobes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise_o, scl_fall_o}));

  p_rise_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise_o |-> (scl_o && !$past(scl_o)));

  p_fall_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall_o |-> (!scl_o && $past(scl_o)));

  p_idle_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (scl_o && !scl_rise_o && !scl_fall_o));

  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |=> scl_fall_o);

  p_min_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise_o |-> (low_run_q >= 16'd4));
endmodule

bind scl_duty_gen scl_duty_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .scl_o      (scl_o),
  .scl_rise_o (scl_rise_o),
  .scl_fall_o (scl_fall_o)
);

// File: tb/test_scl_duty_gen.sv
module test_scl_duty_gen;
  logic        clk;
  logic        rst_n;
  logic        en;
  logic [15:0] lo;
  logic [15:0] hi;
  logic        scl, rise, fall;

  int n_cmp  = 0;
  int n_bad  = 0;
  int cycles = 0;
  bit done   = 0;
  string cur_req = "R1";

  // reference model state
  int  m_on, m_scl, m_rise, m_fall, m_left;

  scl_duty_gen i_scl_duty_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .low_cnt_i  (lo),
    .high_cnt_i (hi),
    .scl_o      (scl),
    .scl_rise_o (rise),
    .scl_fall_o (fall)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int eff(input int v);
    return (v < 4) ? 4 : v;
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: cycles left in the current phase.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_on = 0; m_scl = 1; m_rise = 0; m_fall = 0; m_left = 0;
    end else if (!en) begin
      m_on = 0; m_scl = 1; m_rise = 0; m_fall = 0;
    end else if (m_on == 0) begin
      m_on = 1; m_scl = 0; m_fall = 1; m_rise = 0; m_left = eff(int'(lo));
    end else begin
      m_left = m_left - 1;
      m_rise = 0; m_fall = 0;
      if (m_left == 0) begin
        if (m_scl == 1) begin
          m_scl = 0; m_fall = 1; m_left = eff(int'(lo));
        end else begin
          m_scl = 1; m_rise = 1; m_left = eff(int'(hi));
        end
      end
    end
  end

  // Compare against the model on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, int'(scl),  m_scl,  "scl level vs model");
      check(cur_req, int'(rise), m_rise, "rise strobe vs model");
      check(cur_req, int'(fall), m_fall, "fall strobe vs model");
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected at most 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wait_fall();
    do @(negedge clk); while (!fall);
  endtask

  // From a negedge showing a strobe, count cycles until the next strobe.
  task automatic run_len(output int n);
    n = 1;
    @(negedge clk);
    while (!rise && !fall) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    rst_n = 1'b0; en = 1'b0; lo = 16'd5; hi = 16'd7;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(scl), 1, "scl during reset");
    check("R1", int'(rise), 0, "rise during reset");
    check("R1", int'(fall), 0, "fall during reset");
    rst_n = 1'b1;

    // R2: idle with enable low
    cur_req = "R2";
    lo = 16'd0; hi = 16'd1;
    repeat (6) @(negedge clk);
    check("R2", int'(scl), 1, "scl idle");
    check("R2", int'(rise | fall), 0, "strobes idle");

    // R3: start from idle goes low first
    cur_req = "R3";
    lo = 16'd5; hi = 16'd9;
    en = 1'b1;
    @(negedge clk);
    check("R3", int'(fall), 1, "fall strobe at start");
    check("R3", int'(scl), 0, "scl low at start");

    // R4: independent lengths
    cur_req = "R4";
    run_len(n); check("R4", n, 5, "low phase length");
    run_len(n); check("R4", n, 9, "high phase length");
    check("R8", int'(fall), 1, "fall ends high phase");

    // R5: small and zero counts clamp to 4
    cur_req = "R5";
    lo = 16'd0; hi = 16'd2;
    wait_fall();
    run_len(n); check("R5", n, 4, "zero low count clamped");
    run_len(n); check("R5", n, 4, "small high count clamped");
    repeat (20) @(negedge clk);

    // R6: period equals sum of counts
    cur_req = "R6";
    lo = 16'd40; hi = 16'd60;
    wait_fall();
    do @(negedge clk); while (!rise);
    run_len(n);
    begin
      int m;
      run_len(m);
      check("R6", n + m, 100, "rise-to-rise period");
    end

    // R7: mid-phase write applies at next phase
    cur_req = "R7";
    lo = 16'd10; hi = 16'd10;
    wait_fall();
    wait_fall();
    n = 1;
    repeat (3) begin @(negedge clk); n++; end
    lo = 16'd20;
    @(negedge clk);
    while (!rise) begin n++; @(negedge clk); end
    check("R7", n, 10, "current low phase unchanged");
    run_len(n); check("R7", n, 10, "high phase");
    run_len(n); check("R7", n, 20, "next low phase uses new count");

    // R9: disable mid low phase, then restart
    cur_req = "R9";
    lo = 16'd12; hi = 16'd6;
    wait_fall();
    wait_fall();
    repeat (4) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check("R9", int'(scl), 1, "released on disable");
    check("R9", int'(rise), 0, "no rise strobe on disable");
    repeat (5) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    check("R9", int'(fall), 1, "restart fall strobe");
    run_len(n); check("R9", n, 12, "full low phase after restart");
    check("R8", int'(rise), 1, "rise ends low phase");
    repeat (30) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule